// File: doc/BRIEF.md
# Vectored Interrupt Line Controller

This block collects up to 64 interrupt request lines and turns their activity into a stream of assert and deassert events. Each event carries a per-line 8-bit vector number for a downstream interrupt distributor. For every line it holds a request bit, an in-service bit, a mask bit, a trigger-mode bit (edge or level) and a vector byte. Software reaches this state through a 32-bit register bus. On that bus each 64-bit register is split into a lower and an upper half, and the vector table and the route bytes are addressed one byte at a time.

Line changes, mask writes and write-one-to-clear writes do not produce events directly. Each one marks the affected lines as pending raise or pending lower work. A single service engine takes the lowest pending line once per cycle, evaluates it against the current state and places at most one event on a valid/ready output port. The engine waits only while the output port holds an event that has not been accepted. The event stream therefore keeps ascending line order for work that arrives together, and no burst can overflow the block.

Register map (byte offsets). The fixed words need address bits 1:0 clear, and bit 2 selects the upper half:
- 0x000 identification
- 0x008 mask
- 0x010 trigger mode
- 0x018 enable
- 0x020 request clear
- 0x028 and 0x030 distribution control
- 0x038 polarity
- 0x100 + line: route byte
- 0x200 + line: vector byte

Top module: `irq_vec_router`

## Requirements
- R1: After reset the mask, trigger-mode and enable registers and the vector table read 0, and no event is valid.
- R2: A low-to-high change on an unmasked line's input sets its request bit and produces an assert event (ev_assert=1) carrying that line's vector byte.
- R3: A high-to-low change on a level-mode line (trigger bit 0) clears its request bit, and if the line is in service a deassert event (ev_assert=0) with its vector follows, even while masked.
- R4: On an edge-mode line (trigger bit 1) a falling input is ignored. A 1 written to the clear register at that line's bit clears the request and yields a deassert event. A 1 written for a level-mode line has no effect.
- R5: A rising input on a masked line produces no event, and clearing the mask bit later produces the assert. Setting a mask bit while the request is still high produces no event.
- R6: Events created together (one mask write or simultaneous input changes) leave in ascending line order, one per cycle while ev_ready is high.
- R7: Word registers are written and read as two 32-bit halves: address bit 2 = 1 selects bits 63:32. A write to one half leaves the other half unchanged.
- R8: Each vector byte is written from wdata[7:0] and read back in rdata[7:0] at 0x200 + line.
- R9: Distribution-control and polarity words read 0 after any write. Route bytes read 1 after any write. The identification word reads ID_VAL in its lower half and {ID_COUNT (16 bits), 8'h00, ID_VER} in its upper half.
- R10: Every bus request is acknowledged one cycle later. The acknowledge carries err=1 when the offset is unmapped or a word offset is not 4-byte aligned.
- R11: While ev_valid is high and ev_ready is low, ev_valid, ev_assert and ev_vec hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | Synchronous interrupt request lines |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completed (one cycle after bus_req) |
| bus_err | output | 1 | Access hit an unmapped or misaligned offset |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| ev_ready | input | 1 | Downstream accepts the current event |
| ev_valid | output | 1 | Event present |
| ev_assert | output | 1 | 1 = assert event, 0 = deassert event |
| ev_vec | output | VEC_W | Vector of the line the event belongs to |

## Verification
The hardest situation to reach is several lines becoming due in the same cycle while the downstream port refuses events. Only then do ordering, back-pressure and stability of a held event all matter together. The bench reaches it by raising three request lines while they are masked, which produces no events. It then holds ev_ready low and clears the whole lower mask half in one write, so three assert events become due at once. The same masked lines are later dropped together to obtain three simultaneous deasserts on lines that are still masked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [3:0] {
      SEL_ID,
      SEL_MASK,
      SEL_EDGE,
      SEL_EN,
      SEL_CLR,
      SEL_CTLA,
      SEL_CTLB,
      SEL_POL,
      SEL_ROUTE,
      SEL_VEC,
      SEL_NONE
   } sel_e;

   localparam int RGN_WORDS = 0;
   localparam int RGN_ROUTE = 4;
   localparam int RGN_VEC   = 8;

endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
   import irqc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NLINES = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel,
   output logic              upper,
   output logic [5:0]        byte_idx
);
   timeunit 1ns; timeprecision 1ps;

   localparam int RGN_W = ADDR_W - 6;

   logic [RGN_W-1:0] rgn;

   assign rgn      = addr[ADDR_W-1:6];
   assign byte_idx = addr[5:0];
   assign upper    = addr[2];

   always_comb begin
      sel = SEL_NONE;
      if (rgn == RGN_W'(RGN_WORDS)) begin
         if (addr[1:0] == 2'b00) begin
            unique case (addr[5:3])
               3'd0: sel = SEL_ID;
               3'd1: sel = SEL_MASK;
               3'd2: sel = SEL_EDGE;
               3'd3: sel = SEL_EN;
               3'd4: sel = SEL_CLR;
               3'd5: sel = SEL_CTLA;
               3'd6: sel = SEL_CTLB;
               default: sel = SEL_POL;
            endcase
         end
      end else if (rgn == RGN_W'(RGN_ROUTE)) begin
         if (32'(byte_idx) < NLINES) sel = SEL_ROUTE;
      end else if (rgn == RGN_W'(RGN_VEC)) begin
         if (32'(byte_idx) < NLINES) sel = SEL_VEC;
      end
   end

endmodule

// File: rtl/irqc_first_one.sv
module irqc_first_one #(
   parameter int W  = 64,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   timeunit 1ns; timeprecision 1ps;

   assign any = |vec;

   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/irqc_line_engine.sv
module irqc_line_engine #(
   parameter int NLINES = 64,
   parameter int VEC_W  = 8,
   parameter int LW     = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_in,
   input  logic [NLINES-1:0] mask,
   input  logic [NLINES-1:0] edge_mode,
   input  logic [NLINES-1:0] unmask_hit,
   input  logic [NLINES-1:0] mask_hit,
   input  logic [NLINES-1:0] clr_req,
   input  logic [VEC_W-1:0]  svc_vec,
   output logic [LW-1:0]     svc_idx,
   input  logic              ev_ready,
   output logic              ev_valid,
   output logic              ev_assert,
   output logic [VEC_W-1:0]  ev_vec
);
   timeunit 1ns; timeprecision 1ps;

   logic [NLINES-1:0] prev_in, req, isr, raise_pend, lower_pend;
   logic [NLINES-1:0] rise, fall_lvl, clr_hit, svc_oh;
   logic [NLINES-1:0] req_nx, isr_nx, rp_nx, lp_nx;
   logic              any_pend, go, do_asrt, do_deas;

   assign rise     = irq_in & ~prev_in;
   assign fall_lvl = ~irq_in & prev_in & ~edge_mode;
   assign clr_hit  = clr_req & req & edge_mode;

   irqc_first_one #(.W(NLINES), .IW(LW)) u_pick (
      .vec (raise_pend | lower_pend),
      .any (any_pend),
      .idx (svc_idx)
   );

   assign go      = any_pend && (!ev_valid || ev_ready);
   assign do_asrt = go && raise_pend[svc_idx] && req[svc_idx] && !mask[svc_idx];
   assign do_deas = go && lower_pend[svc_idx] && isr[svc_idx] && !req[svc_idx];
   assign svc_oh  = go ? (NLINES'(1) << svc_idx) : '0;

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      assign req_nx[i] = rise[i] | (req[i] & ~fall_lvl[i] & ~clr_hit[i]);
      assign rp_nx[i]  = rise[i] | unmask_hit[i] | (raise_pend[i] & ~svc_oh[i]);
      assign lp_nx[i]  = fall_lvl[i] | mask_hit[i] | clr_hit[i]
                       | (lower_pend[i] & ~svc_oh[i]);
      assign isr_nx[i] = (svc_oh[i] & do_asrt) | (isr[i] & ~(svc_oh[i] & do_deas));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_in    <= '0;
         req        <= '0;
         isr        <= '0;
         raise_pend <= '0;
         lower_pend <= '0;
         ev_valid   <= 1'b0;
         ev_assert  <= 1'b0;
         ev_vec     <= '0;
      end else begin
         prev_in    <= irq_in;
         req        <= req_nx;
         isr        <= isr_nx;
         raise_pend <= rp_nx;
         lower_pend <= lp_nx;
         if (go) begin
            ev_valid  <= do_asrt | do_deas;
            ev_assert <= do_asrt;
            ev_vec    <= svc_vec;
         end else if (ev_ready) begin
            ev_valid <= 1'b0;
         end
      end
   end

   // R5: an unmasked, requesting line not in service always has raise work queued
   p_no_lost_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req & ~mask & ~isr & ~raise_pend) == '0);

   // R3: a line in service whose request dropped always has lower work queued
   p_no_stale_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (isr & ~req & ~lower_pend) == '0);

   // R4: an edge-mode request only disappears through a clear write
   p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req) & ~req & $past(edge_mode) & ~$past(clr_req)) == '0);

   // R11: a refused event is held unchanged
   p_evt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_assert) && $stable(ev_vec)));

endmodule

// File: rtl/irq_vec_router.sv
module irq_vec_router
   import irqc_pkg::*;
#(
   parameter int          NLINES   = 64,
   parameter int          VEC_W    = 8,
   parameter int          ADDR_W   = 12,
   parameter logic [7:0]  ID_VER   = 8'h01,
   parameter logic [15:0] ID_COUNT = 16'd31,
   parameter logic [31:0] ID_VAL   = 32'h0000_0007
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_in,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_ack,
   output logic              bus_err,
   output logic [31:0]       bus_rdata,
   input  logic              ev_ready,
   output logic              ev_valid,
   output logic              ev_assert,
   output logic [VEC_W-1:0]  ev_vec
);
   timeunit 1ns; timeprecision 1ps;

   localparam int LW = $clog2(NLINES);

   if (NLINES < 2 || NLINES > 64) begin : g_bad_lines
      $error("NLINES must lie in 2..64");
   end
   if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
      $error("VEC_W must lie in 1..8");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must be at least 10");
   end

   sel_e              sel;
   logic              upper;
   logic [5:0]        byte_idx;
   logic [NLINES-1:0] mask, edge_mode, enable;
   logic [VEC_W-1:0]  vec_tbl [NLINES];
   logic [63:0]       cur64, new64, clr64, rd64;
   logic              wr;
   logic [NLINES-1:0] mask_nx, unmask_hit, mask_hit, clr_req;
   logic [LW-1:0]     svc_idx;
   logic [31:0]       rd_word;

   irqc_bus_decode #(.ADDR_W(ADDR_W), .NLINES(NLINES)) u_dec (
      .addr     (bus_addr),
      .sel      (sel),
      .upper    (upper),
      .byte_idx (byte_idx)
   );

   assign wr = bus_req && bus_we;

   always_comb begin
      unique case (sel)
         SEL_MASK: cur64 = 64'(mask);
         SEL_EDGE: cur64 = 64'(edge_mode);
         SEL_EN:   cur64 = 64'(enable);
         default:  cur64 = '0;
      endcase
   end

   assign new64 = upper ? {bus_wdata, cur64[31:0]} : {cur64[63:32], bus_wdata};
   assign clr64 = upper ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};

   assign mask_nx    = new64[NLINES-1:0];
   assign unmask_hit = (wr && sel == SEL_MASK) ? (mask & ~mask_nx) : '0;
   assign mask_hit   = (wr && sel == SEL_MASK) ? (~mask & mask_nx) : '0;
   assign clr_req    = (wr && sel == SEL_CLR) ? clr64[NLINES-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask      <= '0;
         edge_mode <= '0;
         enable    <= '0;
         for (int i = 0; i < NLINES; i++) vec_tbl[i] <= '0;
      end else if (wr) begin
         unique case (sel)
            SEL_MASK: mask      <= mask_nx;
            SEL_EDGE: edge_mode <= new64[NLINES-1:0];
            SEL_EN:   enable    <= new64[NLINES-1:0];
            SEL_VEC:  vec_tbl[byte_idx[LW-1:0]] <= bus_wdata[VEC_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd64 = '0;
      unique case (sel)
         SEL_ID:                    rd64 = {ID_COUNT, 8'h00, ID_VER, ID_VAL};
         SEL_MASK, SEL_EDGE, SEL_EN: rd64 = cur64;
         default: ;
      endcase
      rd_word = upper ? rd64[63:32] : rd64[31:0];
      if (sel == SEL_ROUTE) rd_word = 32'd1;
      if (sel == SEL_VEC)   rd_word = 32'(vec_tbl[byte_idx[LW-1:0]]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_err   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack   <= bus_req;
         bus_err   <= bus_req && (sel == SEL_NONE);
         bus_rdata <= (bus_req && !bus_we) ? rd_word : '0;
      end
   end

   irqc_line_engine #(.NLINES(NLINES), .VEC_W(VEC_W), .LW(LW)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .mask       (mask),
      .edge_mode  (edge_mode),
      .unmask_hit (unmask_hit),
      .mask_hit   (mask_hit),
      .clr_req    (clr_req),
      .svc_vec    (vec_tbl[svc_idx]),
      .svc_idx    (svc_idx),
      .ev_ready   (ev_ready),
      .ev_valid   (ev_valid),
      .ev_assert  (ev_assert),
      .ev_vec     (ev_vec)
   );

   // R10: every request is answered on the following cycle
   p_ack_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_ack);

   // R10: an error is only ever reported with an acknowledge
   p_err_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_ack);

endmodule

// File: tb/sim_irq_vec_router.sv
module sim_irq_vec_router;
   timeunit 1ns; timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_in = '0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ack, bus_err;
   logic [31:0] bus_rdata;
   logic        ev_ready = 1'b1;
   logic        ev_valid, ev_assert;
   logic [7:0]  ev_vec;

   int n_chk = 0;
   int n_fail = 0;
   logic [8:0] evq[$];
   logic       last_err;

   always #2.5 clk = ~clk;

   irq_vec_router u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
      .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_assert(ev_assert), .ev_vec(ev_vec)
   );

   always @(negedge clk) begin
      #1;
      if (rst_n && ev_valid && ev_ready) evq.push_back({ev_assert, ev_vec});
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      last_err = bus_err;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata; last_err = bus_err;
      bus_req = 1'b0;
   endtask

   task automatic chk_events(input string tag, input int n,
                             input logic [8:0] e0, input logic [8:0] e1, input logic [8:0] e2);
      logic [8:0] ex [3];
      ex[0] = e0; ex[1] = e1; ex[2] = e2;
      chk({tag, " event count"}, 64'(evq.size()), 64'(n));
      for (int i = 0; i < n && i < evq.size(); i++)
         chk({tag, " event"}, 64'(evq[i]), 64'(ex[i]));
      evq.delete();
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 ev_valid", 64'(ev_valid), 64'(0));
      bus_rd(12'h008, d); chk("R1 mask lo", 64'(d), 64'(0));
      bus_rd(12'h014, d); chk("R1 edge hi", 64'(d), 64'(0));
      bus_rd(12'h01C, d); chk("R1 enable hi", 64'(d), 64'(0));
      bus_rd(12'h205, d); chk("R1 vector 5", 64'(d), 64'(0));
   endtask

   task automatic t_vectors;
      logic [31:0] d;
      bus_wr(12'h203, 32'hFFFF_FF13);
      bus_wr(12'h205, 32'h0000_0025);
      bus_wr(12'h207, 32'h0000_0017);
      bus_wr(12'h228, 32'h0000_00A8);
      bus_rd(12'h203, d); chk("R8 vector 3", 64'(d), 64'(32'h13));
      bus_rd(12'h228, d); chk("R8 vector 40", 64'(d), 64'(32'hA8));
      bus_rd(12'h206, d); chk("R8 vector 6 untouched", 64'(d), 64'(0));
   endtask

   task automatic t_level;
      irq_in[5] = 1'b1; idle(6);
      chk_events("R2 level raise", 1, {1'b1, 8'h25}, '0, '0);
      irq_in[5] = 1'b0; idle(6);
      chk_events("R3 level drop", 1, {1'b0, 8'h25}, '0, '0);
   endtask

   task automatic t_edge;
      logic [31:0] d;
      bus_wr(12'h014, 32'h0000_0100);
      bus_rd(12'h014, d); chk("R7 edge hi", 64'(d), 64'(32'h100));
      bus_rd(12'h010, d); chk("R7 edge lo", 64'(d), 64'(0));
      irq_in[40] = 1'b1; idle(5);
      irq_in[40] = 1'b0; idle(6);
      chk_events("R4 edge pulse", 1, {1'b1, 8'hA8}, '0, '0);
      bus_wr(12'h020, 32'hFFFF_FFFF); idle(5);
      chk_events("R4 clear other half", 0, '0, '0, '0);
      bus_wr(12'h024, 32'h0000_0100); idle(6);
      chk_events("R4 edge clear", 1, {1'b0, 8'hA8}, '0, '0);
      irq_in[5] = 1'b1; idle(6);
      chk_events("R4 level raise", 1, {1'b1, 8'h25}, '0, '0);
      bus_wr(12'h020, 32'h0000_0020); idle(6);
      chk_events("R4 clear on level line", 0, '0, '0, '0);
      irq_in[5] = 1'b0; idle(6);
      chk_events("R4 level drop after clear", 1, {1'b0, 8'h25}, '0, '0);
   endtask

   task automatic t_mask_burst;
      logic [31:0] d;
      bus_wr(12'h008, 32'hFFFF_FFFF);
      irq_in[3] = 1'b1; irq_in[5] = 1'b1; irq_in[7] = 1'b1;
      idle(6);
      chk_events("R5 masked raise", 0, '0, '0, '0);
      ev_ready = 1'b0;
      bus_wr(12'h008, 32'h0000_0000);
      idle(4);
      chk("R11 held valid", 64'(ev_valid), 64'(1));
      chk("R11 held vector", 64'(ev_vec), 64'(8'h13));
      idle(3);
      chk("R11 still held", 64'({ev_valid, ev_assert, ev_vec}), 64'({1'b1, 1'b1, 8'h13}));
      ev_ready = 1'b1; idle(8);
      chk_events("R6 unmask order", 3, {1'b1, 8'h13}, {1'b1, 8'h25}, {1'b1, 8'h17});
      bus_rd(12'h00C, d); chk("R7 mask hi untouched", 64'(d), 64'(0));
      bus_wr(12'h008, 32'hFFFF_FFFF); idle(6);
      chk_events("R5 mask while requesting", 0, '0, '0, '0);
      irq_in[3] = 1'b0; irq_in[5] = 1'b0; irq_in[7] = 1'b0;
      idle(8);
      chk_events("R3 R6 masked drop order", 3, {1'b0, 8'h13}, {1'b0, 8'h25}, {1'b0, 8'h17});
      bus_wr(12'h008, 32'h0000_0000); idle(6);
      chk_events("R5 unmask idle lines", 0, '0, '0, '0);
   endtask

   task automatic t_halves;
      logic [31:0] d;
      bus_wr(12'h018, 32'h1111_2222);
      bus_wr(12'h01C, 32'h3333_4444);
      bus_wr(12'h018, 32'hAAAA_5555);
      bus_rd(12'h01C, d); chk("R7 enable hi kept", 64'(d), 64'(32'h3333_4444));
      bus_rd(12'h018, d); chk("R7 enable lo", 64'(d), 64'(32'hAAAA_5555));
   endtask

   task automatic t_fixed;
      logic [31:0] d;
      bus_wr(12'h028, 32'hFFFF_FFFF);
      bus_rd(12'h028, d); chk("R9 control A", 64'(d), 64'(0));
      bus_wr(12'h034, 32'h1234_5678);
      bus_rd(12'h034, d); chk("R9 control B hi", 64'(d), 64'(0));
      bus_wr(12'h03C, 32'hFFFF_FFFF);
      bus_rd(12'h03C, d); chk("R9 polarity", 64'(d), 64'(0));
      bus_wr(12'h105, 32'h0);
      bus_rd(12'h105, d); chk("R9 route byte", 64'(d), 64'(1));
      bus_rd(12'h000, d); chk("R9 id lo", 64'(d), 64'(32'h0000_0007));
      bus_rd(12'h004, d); chk("R9 id hi", 64'(d), 64'(32'h001F_0001));
      chk("R10 mapped no err", 64'(last_err), 64'(0));
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      bus_rd(12'h140, d); chk("R10 unmapped read err", 64'(last_err), 64'(1));
      bus_wr(12'h400, 32'h1); chk("R10 unmapped write err", 64'(last_err), 64'(1));
      bus_rd(12'h00A, d); chk("R10 misaligned err", 64'(last_err), 64'(1));
      bus_rd(12'h23F, d); chk("R10 last vector ok", 64'(last_err), 64'(0));
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_vectors();
      t_level();
      t_edge();
      t_mask_burst();
      t_halves();
      t_fixed();
      t_unmapped();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule